// File: doc/BRIEF.md
# Two-Group Interrupt Controller

This block collects level-sensitive interrupt sources and presents them to one processor as two request outputs, IRQ and FIQ. It has a distributor register space and a CPU-interface register space, both behind a simple 32-bit single-cycle read/write bus. Each source line has an enable bit, a latched pending bit, an active bit and a group bit. Group 0 is the secure group and group 1 the non-secure group. Each group has its own acknowledge and end-of-interrupt registers.

An acknowledge read returns the ID of the best eligible interrupt of its group. Best means the numerically lowest priority value, and on a tie the lowest ID. The read clears the pending bit of that ID and marks it active. The interrupt stays silent until software writes its ID to the end-of-interrupt register of the same group. Priorities are fixed per line by a parameter vector. A programmable mask passes only those priority values that are strictly below it. Group 0 requests can be routed to FIQ instead of IRQ.

Top module: `dual_group_intc`

## Requirements
- R1: After reset all enable, pending, active and group bits are 0, both control registers and the mask read 0, and irq_o and fiq_o are low.
- R2: The distributor word at byte address 0x1004 returns, in bits [4:0], the number of 32-line banks minus one (1 for 64 lines).
- R3: A write of ones to 0x1100+4n sets enable bits of bank n, and a write of ones to 0x1180+4n clears them. Zero bits have no effect, and a read of either address returns the current enables.
- R4: The group bank at 0x1080+4n is read/write, and a bit value of 1 places the line in group 1.
- R5: A group is signalled or acknowledged only while both its distributor control bit (0x1000, bit 0 for group 0, bit 1 for group 1) and its CPU control bit (0x2000, same bit positions) are set. Pending state is kept while the group is off.
- R6: The mask register at 0x2004 bits [7:0] admits only interrupts whose priority is strictly lower than the mask value.
- R7: Among eligible interrupts the lowest priority value wins, and on equal priority the lowest ID wins.
- R8: A read of 0x200C acknowledges group 0 and a read of 0x2020 acknowledges group 1. Each returns the ID in bits [9:0], or 1023 with no state change when its group has nothing eligible.
- R9: An acknowledged ID is active and is not signalled or acknowledged again until its ID is written to bits [9:0] of the matching end-of-interrupt register (0x2010 for group 0, 0x2024 for group 1). A write to the other group's register leaves it active.
- R10: Eligible group 1 interrupts raise irq_o. Eligible group 0 interrupts raise irq_o, or fiq_o instead when CPU control bit 3 is set. Each output follows its cause one clock later.
- R11: A pending bit is set on every clock where its source is high and its line is enabled, and it stays set after the source falls. A disabled line never becomes pending. Writing ones to 0x1280+4n clears pending bits, and a read there returns them.
- R12: When a pending clear, by register write or by acknowledge, falls in the same cycle as a high enabled source, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 14 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational during a read |
| src_i | input | NUM_IRQ | Level interrupt sources |
| irq_o | output | 1 | Interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can meet in one cycle: a pending-bit clear, either a write to the clear bank or an acknowledge, and the capture of a still-high enabled source. The bench holds a source high across a clear-bank write. It then reads the pending bank and expects the bit to be set. After the source drops, a second clear must bring the bit to zero. The same race under an acknowledge is judged through R9. A line re-pended while active must give 1023 until its end-of-interrupt, and its ID afterwards.

// File: rtl/dgi_pkg.sv
package dgi_pkg;
  localparam int unsigned ID_W    = 10;
  localparam logic [9:0]  ID_NONE = 10'd1023;
  localparam logic [1:0]  SPACE_DIST = 2'b01;
  localparam logic [1:0]  SPACE_CPU  = 2'b10;
  // distributor bank selectors, offset[11:7]
  localparam logic [4:0] DB_GROUP  = 5'd1;
  localparam logic [4:0] DB_EN_SET = 5'd2;
  localparam logic [4:0] DB_EN_CLR = 5'd3;
  localparam logic [4:0] DB_PD_CLR = 5'd5;
  // cpu interface offsets
  localparam logic [11:0] CO_CTL  = 12'h000;
  localparam logic [11:0] CO_MASK = 12'h004;
  localparam logic [11:0] CO_ACK0 = 12'h00C;
  localparam logic [11:0] CO_EOI0 = 12'h010;
  localparam logic [11:0] CO_ACK1 = 12'h020;
  localparam logic [11:0] CO_EOI1 = 12'h024;
endpackage

// File: rtl/dgi_regs.sv
module dgi_regs #(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned NB = NUM_IRQ / 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [11:0]        off_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_IRQ-1:0] src_i,
  input  logic [NUM_IRQ-1:0] ack_set_i,
  input  logic [NUM_IRQ-1:0] eoi_clr_i,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] grp_o,
  output logic [NUM_IRQ-1:0] act_o
);
  import dgi_pkg::*;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic        hit;
    logic [31:0] en_q, pd_q, gp_q, ac_q;
    logic [31:0] src_b, ack_b, eoi_b;

    assign hit   = wr_i && (off_i[6:2] == 5'(b));
    assign src_b = src_i[b*32 +: 32];
    assign ack_b = ack_set_i[b*32 +: 32];
    assign eoi_b = eoi_clr_i[b*32 +: 32];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q <= '0;
        pd_q <= '0;
        gp_q <= '0;
        ac_q <= '0;
      end else begin
        if (hit && off_i[11:7] == DB_GROUP)  gp_q <= wdata_i;
        if (hit && off_i[11:7] == DB_EN_SET) en_q <= en_q | wdata_i;
        if (hit && off_i[11:7] == DB_EN_CLR) en_q <= en_q & ~wdata_i;
        // a high enabled source overrides any clear in the same cycle
        pd_q <= (pd_q & ~ack_b & ~((hit && off_i[11:7] == DB_PD_CLR) ? wdata_i : 32'd0))
              | (src_b & en_q);
        ac_q <= (ac_q | ack_b) & ~eoi_b;
      end
    end

    assign en_o[b*32 +: 32]   = en_q;
    assign pend_o[b*32 +: 32] = pd_q;
    assign grp_o[b*32 +: 32]  = gp_q;
    assign act_o[b*32 +: 32]  = ac_q;
  end
endmodule

// File: rtl/dgi_pick.sv
module dgi_pick #(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]   elig_i,
  input  logic [NUM_IRQ*8-1:0] prio_i,
  output logic                 valid_o,
  output logic [9:0]           id_o
);
  logic [8:0] best;

  // strict compare keeps the lowest ID on equal priority
  always_comb begin
    best = 9'h100;
    id_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig_i[i] && ({1'b0, prio_i[i*8 +: 8]} < best)) begin
        best = {1'b0, prio_i[i*8 +: 8]};
        id_o = 10'(i);
      end
    end
  end

  assign valid_o = |elig_i;
endmodule

// File: rtl/dual_group_intc.sv
module dual_group_intc #(
  parameter int unsigned NUM_IRQ = 64,
  parameter logic [NUM_IRQ*8-1:0] PRIO_TABLE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [13:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_IRQ-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  import dgi_pkg::*;

  localparam int unsigned NB = NUM_IRQ / 32;
  localparam logic [NUM_IRQ-1:0] ONE = {{(NUM_IRQ-1){1'b0}}, 1'b1};

  logic [11:0] off;
  logic        is_dist, is_cpu, dist_wr, cpu_wr, cpu_rd;
  logic [1:0]  d_ctl;
  logic        c_g0, c_g1, c_fiq;
  logic [7:0]  pmr;
  logic [NUM_IRQ-1:0] en, pend, grp, act, below, elig0, elig1, ack_set, eoi_clr, eoi_mask;
  logic        v0, v1, ack0, ack1, eoi0, eoi1;
  logic [9:0]  id0, id1;
  logic [31:0] grp_w, en_w, pend_w;

  assign off     = addr_i[11:0];
  assign is_dist = req_i && addr_i[13:12] == SPACE_DIST;
  assign is_cpu  = req_i && addr_i[13:12] == SPACE_CPU;
  assign dist_wr = is_dist && we_i;
  assign cpu_wr  = is_cpu && we_i;
  assign cpu_rd  = is_cpu && !we_i;

  dgi_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(dist_wr), .off_i(off), .wdata_i,
    .src_i, .ack_set_i(ack_set), .eoi_clr_i(eoi_clr),
    .en_o(en), .pend_o(pend), .grp_o(grp), .act_o(act)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    assign below[i] = PRIO_TABLE[i*8 +: 8] < pmr;
  end

  logic [NUM_IRQ-1:0] live;
  assign live  = pend & en & ~act & below;
  assign elig0 = live & ~grp & {NUM_IRQ{d_ctl[0] & c_g0}};
  assign elig1 = live &  grp & {NUM_IRQ{d_ctl[1] & c_g1}};

  dgi_pick #(.NUM_IRQ(NUM_IRQ)) u_pick0 (
    .elig_i(elig0), .prio_i(PRIO_TABLE), .valid_o(v0), .id_o(id0));
  dgi_pick #(.NUM_IRQ(NUM_IRQ)) u_pick1 (
    .elig_i(elig1), .prio_i(PRIO_TABLE), .valid_o(v1), .id_o(id1));

  assign ack0 = cpu_rd && off == CO_ACK0;
  assign ack1 = cpu_rd && off == CO_ACK1;
  assign eoi0 = cpu_wr && off == CO_EOI0;
  assign eoi1 = cpu_wr && off == CO_EOI1;

  assign ack_set = (ack0 && v0) ? (ONE << id0) :
                   (ack1 && v1) ? (ONE << id1) : '0;

  // out-of-range IDs shift to zero and retire nothing
  assign eoi_mask = ONE << wdata_i[9:0];
  assign eoi_clr  = (eoi0 && !(|(eoi_mask & grp))) ? eoi_mask :
                    (eoi1 &&  (|(eoi_mask & grp))) ? eoi_mask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_ctl <= '0;
      c_g0  <= 1'b0;
      c_g1  <= 1'b0;
      c_fiq <= 1'b0;
      pmr   <= '0;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      if (dist_wr && off == 12'h000) d_ctl <= wdata_i[1:0];
      if (cpu_wr && off == CO_CTL) begin
        c_g0  <= wdata_i[0];
        c_g1  <= wdata_i[1];
        c_fiq <= wdata_i[3];
      end
      if (cpu_wr && off == CO_MASK) pmr <= wdata_i[7:0];
      irq_o <= v1 || (v0 && !c_fiq);
      fiq_o <= v0 && c_fiq;
    end
  end

  always_comb begin
    grp_w = '0;
    en_w  = '0;
    pend_w = '0;
    for (int b = 0; b < NB; b++) begin
      if (off[6:2] == 5'(b)) begin
        grp_w  = grp[b*32 +: 32];
        en_w   = en[b*32 +: 32];
        pend_w = pend[b*32 +: 32];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_dist && !we_i) begin
      if (off == 12'h000)                                  rdata_o = {30'd0, d_ctl};
      else if (off == 12'h004)                             rdata_o = {27'd0, 5'(NB - 1)};
      else if (off[11:7] == DB_GROUP)                      rdata_o = grp_w;
      else if (off[11:7] == DB_EN_SET || off[11:7] == DB_EN_CLR) rdata_o = en_w;
      else if (off[11:7] == DB_PD_CLR)                     rdata_o = pend_w;
    end else if (cpu_rd) begin
      case (off)
        CO_CTL:  rdata_o = {28'd0, c_fiq, 1'b0, c_g1, c_g0};
        CO_MASK: rdata_o = {24'd0, pmr};
        CO_ACK0: rdata_o = {22'd0, v0 ? id0 : ID_NONE};
        CO_ACK1: rdata_o = {22'd0, v1 ? id1 : ID_NONE};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dgi_chk.sv
module dgi_chk #(
  parameter int unsigned NUM_IRQ = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] src_i,
  input logic [NUM_IRQ-1:0] en,
  input logic [NUM_IRQ-1:0] pend,
  input logic [NUM_IRQ-1:0] act,
  input logic               c_fiq,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               ack_any,
  input logic               ack_hit,
  input logic [9:0]         ack_id,
  input logic [31:0]        rdata_o
);
  localparam logic [NUM_IRQ-1:0] ONE = {{(NUM_IRQ-1){1'b0}}, 1'b1};

  a_r10_fiq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> $past(c_fiq));

  a_r10_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(pend & en & ~act)));

  a_r9_ack_marks_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit |=> |(act & (ONE << $past(ack_id))));

  a_r8_empty_ack_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_any && !ack_hit) |-> rdata_o[9:0] == 10'd1023);

  a_r11_pend_from_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & ~$past(pend) & ~$past(src_i & en)) == '0);
endmodule

bind dual_group_intc dgi_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
  .en(en), .pend(pend), .act(act), .c_fiq(c_fiq),
  .irq_o(irq_o), .fiq_o(fiq_o),
  .ack_any(ack0 || ack1),
  .ack_hit((ack0 && v0) || (ack1 && v1)),
  .ack_id((ack0 && v0) ? id0 : id1),
  .rdata_o(rdata_o)
);

// File: tb/dual_group_intc_bench.sv
`timescale 1ns/1ps
module dual_group_intc_bench;
  localparam int N = 64;

  // priority of ID i is (i mod 8) * 0x20
  function automatic logic [N*8-1:0] mk_prio();
    logic [N*8-1:0] r;
    for (int i = 0; i < N; i++) r[i*8 +: 8] = {i[2:0], 5'd0};
    return r;
  endfunction
  localparam logic [N*8-1:0] TB_PRIO = mk_prio();

  localparam logic [13:0] D = 14'h1000;
  localparam logic [13:0] C = 14'h2000;

  logic clk = 0, rst_ni = 0, req_i = 0, we_i = 0, irq_o, fiq_o;
  logic [13:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [N-1:0] src_i = '0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dual_group_intc #(.NUM_IRQ(N), .PRIO_TABLE(TB_PRIO)) u_dual_group_intc (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .src_i, .irq_o, .fiq_o);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk); #1;
    req_i = 0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); src_i = src_i | m;
    @(negedge clk); src_i = src_i & ~m;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 fiq", {31'd0, fiq_o}, 0);
    rd(D + 14'h000, d); check("R1 dctl", d, 0);
    rd(C + 14'h000, d); check("R1 cctl", d, 0);
    rd(C + 14'h004, d); check("R1 mask", d, 0);
    rd(D + 14'h104, d); check("R1 en", d, 0);
    rd(D + 14'h080, d); check("R1 grp", d, 0);
    rd(D + 14'h004, d); check("R2 type", d, 1);
  endtask

  task automatic t_enable_banks();
    logic [31:0] d;
    wr(D + 14'h100, 32'h0000_00F0);
    wr(D + 14'h100, 32'h0000_0001);
    rd(D + 14'h100, d); check("R3 set", d, 32'hF1);
    wr(D + 14'h180, 32'h0000_0030);
    rd(D + 14'h180, d); check("R3 clr", d, 32'hC1);
    wr(D + 14'h180, 32'hFFFF_FFFF);
    rd(D + 14'h100, d); check("R3 all clr", d, 0);
  endtask

  task automatic t_group_bank();
    logic [31:0] d;
    wr(D + 14'h084, 32'hA5A5_0000);
    rd(D + 14'h084, d); check("R4 grp rw", d, 32'hA5A5_0000);
    wr(D + 14'h084, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(D + 14'h000, 3); wr(C + 14'h000, 3); wr(C + 14'h004, 32'h80);
    wr(D + 14'h100, 32'h0000_000A);  // IDs 1, 3
    wr(D + 14'h104, 32'h0000_0002);  // ID 33
    pulse((64'd1 << 1) | (64'd1 << 3) | (64'd1 << 33));
    settle();
    check("R10 irq g0", {31'd0, irq_o}, 1);
    rd(C + 14'h00C, d); check("R7 tie low id", d, 1);
    rd(C + 14'h00C, d); check("R7 tie second", d, 33);
    rd(C + 14'h00C, d); check("R7 lower prio", d, 3);
    rd(C + 14'h00C, d); check("R8 none", d, 1023);
    wr(C + 14'h010, 1); wr(C + 14'h010, 33); wr(C + 14'h010, 3);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(D + 14'h100, 32'h10);          // ID 4, priority 0x80
    pulse(64'd1 << 4);
    settle();
    check("R6 masked irq", {31'd0, irq_o}, 0);
    rd(C + 14'h00C, d); check("R6 masked ack", d, 1023);
    wr(C + 14'h004, 32'hFF);
    settle();
    check("R6 open irq", {31'd0, irq_o}, 1);
    rd(C + 14'h00C, d); check("R6 open ack", d, 4);
    wr(C + 14'h010, 4);
    wr(C + 14'h004, 32'h80);
    wr(D + 14'h180, 32'h10);
  endtask

  task automatic t_active();
    logic [31:0] d;
    pulse(64'd1 << 1);
    rd(C + 14'h00C, d); check("R9 first ack", d, 1);
    pulse(64'd1 << 1);
    settle();
    check("R9 silent irq", {31'd0, irq_o}, 0);
    rd(C + 14'h00C, d); check("R9 blocked", d, 1023);
    wr(C + 14'h024, 1);
    rd(C + 14'h00C, d); check("R9 wrong eoi", d, 1023);
    wr(C + 14'h010, 1);
    settle();
    check("R9 resignal", {31'd0, irq_o}, 1);
    rd(C + 14'h00C, d); check("R9 after eoi", d, 1);
    wr(C + 14'h010, 1);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(C + 14'h000, 32'hB);
    pulse(64'd1 << 1);
    settle();
    check("R10 fiq", {31'd0, fiq_o}, 1);
    check("R10 no irq", {31'd0, irq_o}, 0);
    rd(C + 14'h00C, d); check("R10 fiq ack", d, 1);
    wr(C + 14'h010, 1);
    wr(D + 14'h080, 32'h8);           // ID 3 to group 1
    pulse(64'd1 << 3);
    settle();
    check("R10 g1 irq", {31'd0, irq_o}, 1);
    check("R10 g1 no fiq", {31'd0, fiq_o}, 0);
    rd(C + 14'h00C, d); check("R8 g0 ack empty", d, 1023);
    rd(C + 14'h020, d); check("R8 g1 ack", d, 3);
    wr(C + 14'h024, 3);
    wr(C + 14'h000, 3);
    wr(D + 14'h080, 0);
  endtask

  task automatic t_grp_enable();
    logic [31:0] d;
    wr(D + 14'h000, 2);
    pulse(64'd1 << 1);
    settle();
    check("R5 off irq", {31'd0, irq_o}, 0);
    rd(C + 14'h00C, d); check("R5 off ack", d, 1023);
    wr(D + 14'h000, 3);
    settle();
    check("R5 on irq", {31'd0, irq_o}, 1);
    rd(C + 14'h00C, d); check("R5 kept pending", d, 1);
    wr(C + 14'h010, 1);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    @(negedge clk); src_i[5] = 1'b1;  // ID 5 disabled
    settle();
    rd(D + 14'h280, d); check("R11 disabled", d & 32'h20, 0);
    @(negedge clk); src_i[5] = 1'b0;
    wr(D + 14'h100, 32'h40);          // ID 6
    @(negedge clk); src_i[6] = 1'b1;
    settle();
    wr(D + 14'h280, 32'h40);
    rd(D + 14'h280, d); check("R12 set beats clr", d & 32'h40, 32'h40);
    @(negedge clk); src_i[6] = 1'b0;
    settle();
    rd(D + 14'h280, d); check("R11 latched", d & 32'h40, 32'h40);
    wr(D + 14'h280, 32'h40);
    rd(D + 14'h280, d); check("R11 cleared", d & 32'h40, 0);
    wr(D + 14'h180, 32'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_enable_banks();
    t_group_bank();
    t_priority();
    t_mask();
    t_active();
    t_route();
    t_grp_enable();
    t_pending();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule